// File: doc/BRIEF.md
# Multi-master I2C bus controller

This block is a byte-level I2C controller that can share a two-wire bus with other controllers. It never drives a line high. For each of the clock and data lines it has an output-enable: 1 pulls the line low and 0 releases it. It reads the resolved levels back from the bus. A local command port takes one operation at a time: open a transfer, send a byte, receive a byte, close the transfer, or run a recovery clock burst for a bus that is stuck. Each command ends with a one-cycle `done` pulse. After a byte operation, the received byte, the peer's acknowledge bit and the arbitration result stay valid until the next command is accepted.

All bus timing comes from `clk_div`. One quarter of an SCL period lasts `clk_div + 1` clock cycles. A bit is made of two low quarters followed by two high quarters. The high quarters are counted only once SCL is actually read high, so a target that stretches the clock delays the sampling point. A watcher on the bus tracks start and stop conditions from any source and reports `bus_busy`. A controller that has lost arbitration uses it to wait before trying again.

Top module: `i2c_mm_ctrl`

## Requirements
- R1: After reset both output-enables are 0, `cmd_ready` is 1, `bus_busy` is 0 and no SCL edge is produced.
- R2: Command code 1 (open) on a bus the controller does not own waits, with both lines released and `cmd_ready` at 0, until `bus_busy` is 0 and both lines read high. It then makes SDA fall while SCL is high and finishes with SCL held low.
- R3: Code 1 while the controller owns the bus makes a repeated start: SDA is released, SCL is released, then SDA falls while SCL is high, and SCL is held low again.
- R4: Codes 2 (send) and 3 (receive) give exactly 9 SCL high pulses. Bits go out MSB first, and SDA changes only while SCL is low, so no start or stop condition appears inside a byte.
- R5: For a send, `ack_out` holds the SDA level sampled on the 9th pulse: 0 for acknowledge, 1 for no acknowledge.
- R6: For a receive, `rx_data` holds the 8 sampled bits MSB first, and on the 9th pulse the controller drives `cmd_rd_nack` (0 = acknowledge, 1 = not acknowledged).
- R7: Code 4 (close) makes SDA rise while SCL is high. It leaves both lines released and `bus_busy` at 0.
- R8: While another device holds SCL low after the controller released it, the controller keeps SCL released and waits. Its high phase lasts 2*(`clk_div`+1) cycles, counted from the cycle SCL is first read high.
- R9: If the controller releases SDA to send a 1 and samples SDA low, it releases both lines at once, ends the command with `arb_lost` = 1 and drops ownership. The next accepted command clears `arb_lost`.
- R10: A start condition seen on the bus (SDA falling while SCL is high) sets `bus_busy`. A stop condition (SDA rising while SCL is high) clears it.
- R11: Code 5 (recover) releases SDA and issues SCL pulses until SDA reads high at the end of a pulse, with at most 9 pulses. It then performs the close sequence of R7.
- R12: Codes 2, 3 and 4 given while the controller does not own the bus end with `done` at once and cause no line activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_div | input | DIV_W | Quarter-period length minus one, in clock cycles |
| cmd_valid | input | 1 | Command present |
| cmd_code | input | 3 | 1 open, 2 send, 3 receive, 4 close, 5 recover |
| cmd_data | input | 8 | Byte to send |
| cmd_rd_nack | input | 1 | Acknowledge bit to return after a receive |
| cmd_ready | output | 1 | Controller can accept a command |
| done | output | 1 | One-cycle pulse when a command ends |
| rx_data | output | 8 | Last received byte |
| ack_out | output | 1 | 9th-bit level of the last byte |
| arb_lost | output | 1 | Last byte operation lost arbitration |
| bus_busy | output | 1 | A start condition has been seen and no stop since |
| scl_i | input | 1 | Resolved SCL level |
| sda_i | input | 1 | Resolved SDA level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
The bench holds SCL low in the middle of a bit and measures the high phase from the release. A controller that kept counting during the stretch would show a high phase that is too short, and would sample data before the target let go. Another master is modelled by forcing SDA low while the controller sends a 1. A design that missed the loss would keep clocking, and one that released only SDA would leave SCL toggling. After the loss, a new open command must stay silent until the other master's stop condition. A controller that ignored `bus_busy` would break into a transfer already in progress. Recovery is run once against a target that lets go after three pulses and once against one that never lets go. An off-by-one in the pulse limit, or a missing early exit, shows up directly in the SCL edge count.

// File: rtl/i2c_mm_pkg.sv
package i2c_mm_pkg;

    localparam logic [2:0] OP_START   = 3'd1;
    localparam logic [2:0] OP_WRITE   = 3'd2;
    localparam logic [2:0] OP_READ    = 3'd3;
    localparam logic [2:0] OP_STOP    = 3'd4;
    localparam logic [2:0] OP_RECOVER = 3'd5;

    localparam int unsigned BYTE_BITS  = 8;
    localparam int unsigned FRAME_BITS = BYTE_BITS + 1;

    typedef enum logic [4:0] {
        ST_IDLE,
        ST_WAITFREE,
        ST_STA0, ST_STA1, ST_STA2, ST_STA3,
        ST_LO0, ST_LO1, ST_HI0, ST_HI1, ST_END_LO,
        ST_STO0, ST_STO1, ST_STO2, ST_STO3,
        ST_REC0, ST_REC1, ST_REC2
    } eng_st_e;

endpackage

// File: rtl/i2c_mm_timer.sv
module i2c_mm_timer #(
    parameter int unsigned DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && (cnt_q == div);
        cnt_d = (!run || tick) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_TICK_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (!run) |=> (cnt_q == '0)); // R8
endmodule

// File: rtl/i2c_mm_busmon.sv
module i2c_mm_busmon (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic busy
);
    typedef struct packed {
        logic scl;
        logic sda;
        logic busy;
    } mon_s;

    mon_s mon_d, mon_q;
    logic start_seen, stop_seen;

    always_comb begin
        start_seen = mon_q.scl && scl_i && mon_q.sda && !sda_i;
        stop_seen  = mon_q.scl && scl_i && !mon_q.sda && sda_i;
        mon_d      = mon_q;
        mon_d.scl  = scl_i;
        mon_d.sda  = sda_i;
        if (start_seen)     mon_d.busy = 1'b1;
        else if (stop_seen) mon_d.busy = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mon_q <= '{scl: 1'b1, sda: 1'b1, busy: 1'b0};
        else        mon_q <= mon_d;
    end

    assign busy = mon_q.busy;

    AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        start_seen |=> busy); // R10
    AST_FREE_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        stop_seen |=> !busy); // R10
endmodule

// File: rtl/i2c_mm_engine.sv
module i2c_mm_engine
    import i2c_mm_pkg::*;
#(
    parameter int unsigned REC_PULSES = 9
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [2:0] cmd_code,
    input  logic [7:0] cmd_data,
    input  logic       cmd_rd_nack,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic       bus_busy,
    input  logic       tick,
    output logic       tmr_run,
    output logic       cmd_ready,
    output logic       done,
    output logic [7:0] rx_data,
    output logic       ack_out,
    output logic       arb_lost,
    output logic       scl_oe,
    output logic       sda_oe
);
    localparam int unsigned REC_W = $clog2(REC_PULSES + 1);

    typedef struct packed {
        eng_st_e                 st;
        logic                    scl_oe;
        logic                    sda_oe;
        logic                    own;
        logic [FRAME_BITS-1:0]   tx;
        logic [FRAME_BITS-1:0]   drv;
        logic [FRAME_BITS-1:0]   rx;
        logic [3:0]              bcnt;
        logic [REC_W-1:0]        pcnt;
        logic                    done;
        logic                    arb;
        logic                    ack;
        logic [BYTE_BITS-1:0]    rxd;
    } eng_s;

    eng_s q, d;
    logic wait_hi;

    always_comb begin
        wait_hi = q.st inside {ST_STA1, ST_HI0, ST_STO2, ST_REC1};
        tmr_run = !(q.st inside {ST_IDLE, ST_WAITFREE}) && !(wait_hi && !scl_i);
    end

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (cmd_valid) begin
                    case (cmd_code)
                        OP_START: begin
                            d.arb    = 1'b0;
                            d.sda_oe = q.own ? 1'b0 : q.sda_oe;
                            d.st     = q.own ? ST_STA0 : ST_WAITFREE;
                        end
                        OP_WRITE, OP_READ: begin
                            d.arb = 1'b0;
                            if (q.own) begin
                                d.bcnt = '0;
                                if (cmd_code == OP_WRITE) begin
                                    d.tx  = {cmd_data, 1'b1};
                                    d.drv = {{BYTE_BITS{1'b1}}, 1'b0};
                                end else begin
                                    d.tx  = {{BYTE_BITS{1'b1}}, cmd_rd_nack};
                                    d.drv = {{BYTE_BITS{1'b0}}, 1'b1};
                                end
                                d.st = ST_LO0;
                            end else begin
                                d.done = 1'b1;
                            end
                        end
                        OP_STOP: begin
                            d.arb = 1'b0;
                            if (q.own) d.st   = ST_STO0;
                            else       d.done = 1'b1;
                        end
                        OP_RECOVER: begin
                            d.arb    = 1'b0;
                            d.pcnt   = '0;
                            d.scl_oe = 1'b1;
                            d.sda_oe = 1'b0;
                            d.st     = ST_REC0;
                        end
                        default: ;
                    endcase
                end
            end
            ST_WAITFREE: begin
                if (!bus_busy && scl_i && sda_i) begin
                    d.sda_oe = 1'b0;
                    d.st     = ST_STA0;
                end
            end
            ST_STA0: if (tick) begin d.scl_oe = 1'b0; d.st = ST_STA1; end
            ST_STA1: if (tick) begin d.sda_oe = 1'b1; d.st = ST_STA2; end
            ST_STA2: if (tick) begin d.scl_oe = 1'b1; d.st = ST_STA3; end
            ST_STA3: if (tick) begin d.own = 1'b1; d.done = 1'b1; d.st = ST_IDLE; end
            ST_LO0: if (tick) begin d.sda_oe = !q.tx[FRAME_BITS-1]; d.st = ST_LO1; end
            ST_LO1: if (tick) begin d.scl_oe = 1'b0; d.st = ST_HI0; end
            ST_HI0: begin
                if (tick) begin
                    d.rx = {q.rx[FRAME_BITS-2:0], sda_i};
                    if (q.drv[FRAME_BITS-1] && q.tx[FRAME_BITS-1] && !sda_i) begin
                        d.scl_oe = 1'b0;
                        d.sda_oe = 1'b0;
                        d.own    = 1'b0;
                        d.arb    = 1'b1;
                        d.done   = 1'b1;
                        d.st     = ST_IDLE;
                    end else begin
                        d.st = ST_HI1;
                    end
                end
            end
            ST_HI1: begin
                if (tick) begin
                    d.tx     = {q.tx[FRAME_BITS-2:0], 1'b1};
                    d.drv    = {q.drv[FRAME_BITS-2:0], 1'b0};
                    d.bcnt   = q.bcnt + 1'b1;
                    d.scl_oe = 1'b1;
                    d.st     = (q.bcnt == 4'(FRAME_BITS - 1)) ? ST_END_LO : ST_LO0;
                end
            end
            ST_END_LO: begin
                if (tick) begin
                    d.sda_oe = 1'b0;
                    d.rxd    = q.rx[FRAME_BITS-1:1];
                    d.ack    = q.rx[0];
                    d.done   = 1'b1;
                    d.st     = ST_IDLE;
                end
            end
            ST_STO0: if (tick) begin d.sda_oe = 1'b1; d.st = ST_STO1; end
            ST_STO1: if (tick) begin d.scl_oe = 1'b0; d.st = ST_STO2; end
            ST_STO2: if (tick) begin d.sda_oe = 1'b0; d.st = ST_STO3; end
            ST_STO3: if (tick) begin d.own = 1'b0; d.done = 1'b1; d.st = ST_IDLE; end
            ST_REC0: if (tick) begin d.scl_oe = 1'b0; d.st = ST_REC1; end
            ST_REC1: if (tick) begin d.pcnt = q.pcnt + 1'b1; d.st = ST_REC2; end
            ST_REC2: begin
                if (tick) begin
                    d.scl_oe = 1'b1;
                    d.st     = (sda_i || q.pcnt == REC_W'(REC_PULSES)) ? ST_STO0 : ST_REC0;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, tx: '1, default: '0};
        else        q <= d;
    end

    assign cmd_ready = (q.st == ST_IDLE);
    assign done      = q.done;
    assign rx_data   = q.rxd;
    assign ack_out   = q.ack;
    assign arb_lost  = q.arb;
    assign scl_oe    = q.scl_oe;
    assign sda_oe    = q.sda_oe;

    AST_WAIT_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_WAITFREE) |-> (!q.scl_oe && !q.sda_oe)); // R2
    AST_SDA_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.st inside {ST_HI0, ST_HI1}) && ($past(q.st) inside {ST_HI0, ST_HI1})) |-> $stable(q.sda_oe)); // R4
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE && !q.own) |-> (!q.scl_oe && !q.sda_oe)); // R7
    AST_STRETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_HI0 && !scl_i) |=> (q.st == ST_HI0 && !q.scl_oe)); // R8
    AST_ARB_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.arb) |-> (!q.scl_oe && !q.sda_oe && !q.own)); // R9
    AST_REC_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (q.pcnt <= REC_W'(REC_PULSES))); // R11
endmodule

// File: rtl/i2c_mm_ctrl.sv
module i2c_mm_ctrl #(
    parameter int unsigned DIV_W      = 12,
    parameter int unsigned REC_PULSES = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] clk_div,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_code,
    input  logic [7:0]       cmd_data,
    input  logic             cmd_rd_nack,
    output logic             cmd_ready,
    output logic             done,
    output logic [7:0]       rx_data,
    output logic             ack_out,
    output logic             arb_lost,
    output logic             bus_busy,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             scl_oe,
    output logic             sda_oe
);
    logic tmr_run, tick;

    i2c_mm_timer #(.DIV_W(DIV_W)) i_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (tmr_run),
        .div  (clk_div),
        .tick (tick)
    );

    i2c_mm_busmon i_busmon (
        .clk  (clk),
        .rst_n(rst_n),
        .scl_i(scl_i),
        .sda_i(sda_i),
        .busy (bus_busy)
    );

    i2c_mm_engine #(.REC_PULSES(REC_PULSES)) i_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_code   (cmd_code),
        .cmd_data   (cmd_data),
        .cmd_rd_nack(cmd_rd_nack),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .bus_busy   (bus_busy),
        .tick       (tick),
        .tmr_run    (tmr_run),
        .cmd_ready  (cmd_ready),
        .done       (done),
        .rx_data    (rx_data),
        .ack_out    (ack_out),
        .arb_lost   (arb_lost),
        .scl_oe     (scl_oe),
        .sda_oe     (sda_oe)
    );
endmodule

// File: tb/test_i2c_mm_ctrl.sv
`timescale 1ns/1ps
module test_i2c_mm_ctrl;
    localparam int DIV = 3;
    localparam logic [2:0] C_START = 3'd1, C_WRITE = 3'd2, C_READ = 3'd3,
                           C_STOP = 3'd4, C_REC = 3'd5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [11:0] clk_div = 12'(DIV);
    logic cmd_valid = 1'b0;
    logic [2:0] cmd_code = '0;
    logic [7:0] cmd_data = '0;
    logic cmd_rd_nack = 1'b0;
    logic cmd_ready, done, ack_out, arb_lost, bus_busy, scl_oe, sda_oe;
    logic [7:0] rx_data;
    logic ext_scl_low = 1'b0, ext_sda_low = 1'b0;
    logic scl_line, sda_line;

    assign scl_line = !(scl_oe || ext_scl_low);
    assign sda_line = !(sda_oe || ext_sda_low);

    i2c_mm_ctrl i_i2c_mm_ctrl (
        .clk(clk), .rst_n(rst_n), .clk_div(clk_div),
        .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_data(cmd_data),
        .cmd_rd_nack(cmd_rd_nack), .cmd_ready(cmd_ready), .done(done),
        .rx_data(rx_data), .ack_out(ack_out), .arb_lost(arb_lost),
        .bus_busy(bus_busy), .scl_i(scl_line), .sda_i(sda_line),
        .scl_oe(scl_oe), .sda_oe(sda_oe)
    );

    always #5 clk = !clk;

    int n_chk = 0, n_fail = 0;
    int n_start = 0, n_stop = 0, n_rise = 0;
    logic scl_p = 1'b1, sda_p = 1'b1;

    always @(posedge clk) begin
        if (scl_p && scl_line && sda_p && !sda_line) n_start++;
        if (scl_p && scl_line && !sda_p && sda_line) n_stop++;
        if (!scl_p && scl_line) n_rise++;
        scl_p <= scl_line;
        sda_p <= sda_line;
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic send_cmd(input logic [2:0] c, input logic [7:0] dat, input logic nk);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_code = c; cmd_data = dat; cmd_rd_nack = nk;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1", "scl_oe", int'(scl_oe), 0);
        chk("R1", "sda_oe", int'(sda_oe), 0);
        chk("R1", "cmd_ready", int'(cmd_ready), 1);
        chk("R1", "bus_busy", int'(bus_busy), 0);
        chk("R1", "scl edges", n_rise, 0);
    endtask

    task automatic t_ignored();
        int r0 = n_rise;
        int p0 = n_stop;
        send_cmd(C_WRITE, 8'hFF, 1'b0);
        chk("R12", "done at once on unowned send", int'(done), 1);
        send_cmd(C_STOP, 8'h00, 1'b0);
        chk("R12", "done at once on unowned close", int'(done), 1);
        repeat (4) @(negedge clk);
        chk("R12", "scl_oe stays released", int'(scl_oe), 0);
        chk("R12", "no scl edges", n_rise - r0, 0);
        chk("R12", "no stop produced", n_stop - p0, 0);
    endtask

    task automatic t_start(input string req);
        int s0 = n_start;
        send_cmd(C_START, 8'h00, 1'b0);
        wait_done();
        chk(req, "one start condition", n_start - s0, 1);
        chk(req, "scl held low after start", int'(scl_line), 0);
        chk("R10", "busy after start", int'(bus_busy), 1);
    endtask

    task automatic t_write(input logic [7:0] dat, input logic give_ack);
        logic [7:0] got = '0;
        int s0 = n_start;
        int p0 = n_stop;
        int r0 = n_rise;
        send_cmd(C_WRITE, dat, 1'b0);
        for (int i = 0; i < 8; i++) begin
            @(posedge scl_line);
            got = {got[6:0], sda_line};
        end
        @(negedge scl_line); @(negedge clk); ext_sda_low = give_ack;
        @(posedge scl_line); @(negedge scl_line); @(negedge clk); ext_sda_low = 1'b0;
        wait_done();
        chk("R4", "bits on bus MSB first", int'(got), int'(dat));
        chk("R4", "nine pulses", n_rise - r0, 9);
        chk("R4", "no start/stop inside byte", (n_start - s0) + (n_stop - p0), 0);
        chk("R5", "ack_out", int'(ack_out), int'(!give_ack));
    endtask

    task automatic t_read(input logic [7:0] dat, input logic nk);
        logic m;
        @(negedge clk); ext_sda_low = !dat[7];
        send_cmd(C_READ, 8'h00, nk);
        for (int i = 0; i < 8; i++) begin
            @(posedge scl_line); @(negedge scl_line); @(negedge clk);
            ext_sda_low = (i < 7) ? !dat[6 - i] : 1'b0;
        end
        @(posedge scl_line);
        m = sda_line;
        wait_done();
        chk("R6", "rx_data", int'(rx_data), int'(dat));
        chk("R6", "9th bit driven by controller", int'(m), int'(nk));
    endtask

    task automatic t_repeat();
        int s0 = n_start;
        int p0 = n_stop;
        send_cmd(C_START, 8'h00, 1'b0);
        wait_done();
        chk("R3", "repeated start seen", n_start - s0, 1);
        chk("R3", "no stop before it", n_stop - p0, 0);
        chk("R3", "scl low after", int'(scl_line), 0);
        chk("R3", "still busy", int'(bus_busy), 1);
    endtask

    task automatic t_stop();
        int p0 = n_stop;
        send_cmd(C_STOP, 8'h00, 1'b0);
        wait_done();
        @(negedge clk);
        chk("R7", "stop condition", n_stop - p0, 1);
        chk("R7", "lines released", int'({scl_oe, sda_oe}), 0);
        chk("R10", "bus free", int'(bus_busy), 0);
    endtask

    task automatic t_stretch();
        int r0, n;
        send_cmd(C_WRITE, 8'h81, 1'b0);
        @(negedge clk); ext_scl_low = 1'b1;
        while (scl_oe) @(negedge clk);
        r0 = n_rise;
        repeat (40) @(negedge clk);
        chk("R8", "scl kept released while stretched", int'(scl_oe), 0);
        chk("R8", "no edge while stretched", n_rise - r0, 0);
        ext_scl_low = 1'b0;
        n = 0;
        while (!scl_oe) begin @(negedge clk); n++; end
        chk("R8", "high phase length", n, 2 * (DIV + 1));
        wait_done();
        chk("R5", "no ack gives 1", int'(ack_out), 1);
    endtask

    task automatic t_arb();
        int r0;
        @(negedge clk); ext_sda_low = 1'b1;
        r0 = n_rise;
        send_cmd(C_WRITE, 8'h40, 1'b0);
        wait_done();
        chk("R9", "arb_lost", int'(arb_lost), 1);
        chk("R9", "both released", int'({scl_oe, sda_oe}), 0);
        chk("R9", "stopped at second bit", n_rise - r0, 2);
        chk("R10", "still busy (other master)", int'(bus_busy), 1);
        send_cmd(C_START, 8'h00, 1'b0);
        repeat (60) @(negedge clk);
        chk("R2", "waits released while busy", int'({scl_oe, sda_oe}), 0);
        chk("R2", "not ready while waiting", int'(cmd_ready), 0);
        ext_sda_low = 1'b0;
        wait_done();
        chk("R9", "arb_lost cleared by new command", int'(arb_lost), 0);
        chk("R2", "owns bus after waiting", int'(scl_line), 0);
        chk("R10", "busy again", int'(bus_busy), 1);
    endtask

    task automatic t_recover_early();
        int r0;
        @(negedge clk); ext_sda_low = 1'b1;
        r0 = n_rise;
        send_cmd(C_REC, 8'h00, 1'b0);
        for (int i = 0; i < 3; i++) @(posedge scl_line);
        @(negedge clk); ext_sda_low = 1'b0;
        wait_done();
        @(negedge clk);
        chk("R11", "three pulses plus stop", n_rise - r0, 4);
        chk("R11", "lines high", int'({scl_line, sda_line}), 3);
        chk("R10", "free after recovery", int'(bus_busy), 0);
    endtask

    task automatic t_recover_full();
        int r0;
        @(negedge clk); ext_sda_low = 1'b1;
        r0 = n_rise;
        send_cmd(C_REC, 8'h00, 1'b0);
        wait_done();
        chk("R11", "nine pulses plus stop", n_rise - r0, 10);
        ext_sda_low = 1'b0;
        repeat (2) @(negedge clk);
        chk("R10", "free after target lets go", int'(bus_busy), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ignored();
        t_start("R2");
        t_write(8'hA4, 1'b1);
        t_write(8'h5B, 1'b0);
        t_repeat();
        t_write(8'hA5, 1'b1);
        t_read(8'h3C, 1'b0);
        t_read(8'hC3, 1'b1);
        t_stop();
        t_start("R2");
        t_stretch();
        t_stop();
        t_start("R2");
        t_arb();
        t_stop();
        t_recover_early();
        t_recover_full();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule